// File: doc/BRIEF.md
# Machine-mode CSR and trap unit

This block holds the four machine-level control and status registers of a single-cycle 32-bit core: status, trap vector, exception PC and trap cause. The decoder presents a CSR address, an operation code and an operand each cycle. The unit returns the current register value on a combinational read port. It commits the operation (replace, set bits or clear bits) on the next rising clock edge.

The decoder also supplies a 2-bit trap code. On an environment call or an illegal instruction, the unit records the PC of the faulting instruction and a cause value, and asks the PC logic to jump to the trap vector. On return from trap, it asks for a jump to the stored exception PC and leaves every register unchanged. An address outside the four implemented registers is flagged so that the decoder can raise an illegal-instruction trap. An access to such an address never changes any register.

Top module: `mtrap_csr`

## Requirements
- R1: A synchronous active-high reset clears all four registers, so each reads 0 on the cycle after reset.
- R2: Addresses 0x300 (status), 0x305 (trap vector), 0x341 (exception PC) and 0x342 (cause) read combinationally with `csr_illegal` low. Any other address reads 0 with `csr_illegal` high.
- R3: Operation 01 (replace) returns the old value in the same cycle and stores the operand at the next edge. A write is seen by reads only from the following cycle, with no bypass.
- R4: Operation 10 (set) stores old OR operand. With a zero operand it returns the value and leaves the register unchanged.
- R5: Operation 11 (clear) stores old AND NOT operand. Operation 00 writes nothing.
- R6: An operation on an unimplemented address changes none of the four registers.
- R7: Trap code 01 (environment call) drives `redirect` high with `redirect_pc` equal to the trap vector. At the edge it stores `pc` into the exception PC and 11 into the cause register.
- R8: Trap code 10 (illegal instruction) redirects to the trap vector. At the edge it stores `pc` into the exception PC and 2 into the cause register.
- R9: Trap code 11 (return from trap) redirects to the exception PC value and changes no register.
- R10: Trap code 00 keeps `redirect` low.
- R11: When any trap code is nonzero, a CSR operation in the same cycle is suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | CSR address of the current instruction |
| csr_op | input | 2 | 00 none, 01 replace, 10 set bits, 11 clear bits |
| csr_operand | input | 32 | Source value for the CSR operation |
| trap_code | input | 2 | 00 none, 01 environment call, 10 illegal, 11 return from trap |
| pc | input | 32 | PC of the current instruction |
| csr_rdata | output | 32 | Current value of the addressed CSR (0 if unimplemented) |
| csr_illegal | output | 1 | Addressed CSR is not implemented |
| redirect | output | 1 | Next PC must come from `redirect_pc` |
| redirect_pc | output | 32 | Trap vector or exception PC |

## Verification
A corrupted register shows at the ports in one of two ways. It appears on `csr_rdata` in the first cycle its address is presented. For the trap vector and exception PC, it also appears on `redirect_pc` in the very cycle a trap or return is signalled. The bench therefore reads every register back right after each operation and each trap. A lost or misdirected write, or a write that slips past a trap, then shows up one cycle after the edge that should have (or should not have) changed it. The cause and exception PC are both checked after each trap. A swapped cause code or a stale PC is therefore caught on the next read.

// File: rtl/mtrap_csr.sv
module mtrap_csr #(
  parameter int XLEN = 32,
  parameter int AW   = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   csr_addr,
  input  logic [1:0]      csr_op,
  input  logic [XLEN-1:0] csr_operand,
  input  logic [1:0]      trap_code,
  input  logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_illegal,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_pc
);
  localparam logic [AW-1:0]   A_STATUS = AW'(12'h300);
  localparam logic [AW-1:0]   A_TVEC   = AW'(12'h305);
  localparam logic [AW-1:0]   A_EPC    = AW'(12'h341);
  localparam logic [AW-1:0]   A_CAUSE  = AW'(12'h342);
  localparam logic [XLEN-1:0] C_ECALL  = XLEN'(11);
  localparam logic [XLEN-1:0] C_ILLEG  = XLEN'(2);

  logic [XLEN-1:0] status_q, tvec_q, epc_q, cause_q;
  logic [XLEN-1:0] new_val;
  logic hit_st, hit_tv, hit_ep, hit_ca, take_trap, wr_en;

  assign hit_st = csr_addr == A_STATUS;
  assign hit_tv = csr_addr == A_TVEC;
  assign hit_ep = csr_addr == A_EPC;
  assign hit_ca = csr_addr == A_CAUSE;
  assign csr_illegal = !(hit_st || hit_tv || hit_ep || hit_ca);

  assign csr_rdata = ({XLEN{hit_st}} & status_q) | ({XLEN{hit_tv}} & tvec_q)
                   | ({XLEN{hit_ep}} & epc_q)    | ({XLEN{hit_ca}} & cause_q);

  always_comb begin
    case (csr_op)
      2'b01:   new_val = csr_operand;
      2'b10:   new_val = csr_rdata | csr_operand;
      2'b11:   new_val = csr_rdata & ~csr_operand;
      default: new_val = csr_rdata;
    endcase
  end

  assign take_trap = trap_code == 2'b01 || trap_code == 2'b10;
  assign wr_en = csr_op != 2'b00 && !csr_illegal && trap_code == 2'b00
              && !(csr_op == 2'b10 && csr_operand == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      tvec_q   <= '0;
      epc_q    <= '0;
      cause_q  <= '0;
    end else if (take_trap) begin
      epc_q   <= pc;
      cause_q <= (trap_code == 2'b01) ? C_ECALL : C_ILLEG;
    end else if (wr_en) begin
      if (hit_st) status_q <= new_val;
      if (hit_tv) tvec_q   <= new_val;
      if (hit_ep) epc_q    <= new_val;
      if (hit_ca) cause_q  <= new_val;
    end
  end

  assign redirect    = trap_code != 2'b00;
  assign redirect_pc = (trap_code == 2'b11) ? epc_q : tvec_q;
endmodule

module mtrap_csr_chk #(
  parameter int XLEN = 32,
  parameter int AW   = 12
) (
  input logic            clk,
  input logic            rst,
  input logic [AW-1:0]   csr_addr,
  input logic [1:0]      csr_op,
  input logic [XLEN-1:0] csr_operand,
  input logic [1:0]      trap_code,
  input logic [XLEN-1:0] pc,
  input logic            csr_illegal,
  input logic            redirect,
  input logic [XLEN-1:0] status_q,
  input logic [XLEN-1:0] tvec_q,
  input logic [XLEN-1:0] epc_q,
  input logic [XLEN-1:0] cause_q
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (status_q == '0 && tvec_q == '0 && epc_q == '0 && cause_q == '0)); // R1
  AST_SET_ZERO_HOLD: assert property (@(posedge clk) disable iff (rst) (trap_code == 2'b00 && csr_op == 2'b10 && csr_operand == '0) |=> ($stable(status_q) && $stable(tvec_q) && $stable(epc_q) && $stable(cause_q))); // R4
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst) (trap_code == 2'b00 && csr_illegal) |=> ($stable(status_q) && $stable(tvec_q) && $stable(epc_q) && $stable(cause_q))); // R6
  AST_TRAP_SAVES_PC: assert property (@(posedge clk) disable iff (rst) (trap_code == 2'b01 || trap_code == 2'b10) |=> epc_q == $past(pc)); // R7
  AST_ECALL_CAUSE: assert property (@(posedge clk) disable iff (rst) trap_code == 2'b01 |=> cause_q == XLEN'(11)); // R7
  AST_ILLEGAL_CAUSE: assert property (@(posedge clk) disable iff (rst) trap_code == 2'b10 |=> cause_q == XLEN'(2)); // R8
  AST_RETURN_HOLDS: assert property (@(posedge clk) disable iff (rst) trap_code == 2'b11 |=> ($stable(status_q) && $stable(tvec_q) && $stable(epc_q) && $stable(cause_q))); // R9
  AST_NO_REDIRECT: assert property (@(posedge clk) disable iff (rst) trap_code == 2'b00 |-> !redirect); // R10
  AST_TRAP_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst) (trap_code != 2'b00 && csr_op != 2'b00) |=> ($stable(status_q) && $stable(tvec_q))); // R11
endmodule

bind mtrap_csr mtrap_csr_chk #(.XLEN(XLEN), .AW(AW)) chk (
  .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_op(csr_op),
  .csr_operand(csr_operand), .trap_code(trap_code), .pc(pc),
  .csr_illegal(csr_illegal), .redirect(redirect),
  .status_q(status_q), .tvec_q(tvec_q), .epc_q(epc_q), .cause_q(cause_q)
);

// File: tb/mtrap_csr_test.sv
module mtrap_csr_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  op;
    logic [11:0] addr;
    logic [31:0] wd;
    logic [1:0]  trap;
    logic [31:0] pc;
    logic [31:0] rd;
    logic        ill;
    logic        redir;
    logic [31:0] tgt;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 12'h300, 32'h0,        2'd0, 32'h0,   32'h0,        1'b0, 1'b0, 32'h0,   8'd1},  // R1 read after reset
    '{2'd1, 12'h305, 32'h100,      2'd0, 32'h0,   32'h0,        1'b0, 1'b0, 32'h0,   8'd3},  // R3 replace, old value
    '{2'd0, 12'h305, 32'h0,        2'd0, 32'h0,   32'h100,      1'b0, 1'b0, 32'h0,   8'd3},  // R3 visible next cycle
    '{2'd1, 12'h300, 32'hFF00FF00, 2'd0, 32'h0,   32'h0,        1'b0, 1'b0, 32'h0,   8'd3},
    '{2'd2, 12'h300, 32'h000000FF, 2'd0, 32'h0,   32'hFF00FF00, 1'b0, 1'b0, 32'h0,   8'd4},  // R4 set
    '{2'd2, 12'h300, 32'h0,        2'd0, 32'h0,   32'hFF00FFFF, 1'b0, 1'b0, 32'h0,   8'd4},  // R4 zero operand
    '{2'd3, 12'h300, 32'h0F0000F0, 2'd0, 32'h0,   32'hFF00FFFF, 1'b0, 1'b0, 32'h0,   8'd4},  // R4 unchanged
    '{2'd0, 12'h300, 32'h0,        2'd0, 32'h0,   32'hF000FF0F, 1'b0, 1'b0, 32'h0,   8'd5},  // R5 clear result
    '{2'd1, 12'h7C0, 32'hDEAD,     2'd0, 32'h0,   32'h0,        1'b1, 1'b0, 32'h0,   8'd2},  // R2 unimplemented
    '{2'd0, 12'h342, 32'h0,        2'd0, 32'h0,   32'h0,        1'b0, 1'b0, 32'h0,   8'd6},  // R6 cause untouched
    '{2'd0, 12'h341, 32'h0,        2'd0, 32'h0,   32'h0,        1'b0, 1'b0, 32'h0,   8'd6},  // R6 epc untouched
    '{2'd0, 12'h305, 32'h0,        2'd0, 32'h0,   32'h100,      1'b0, 1'b0, 32'h0,   8'd6},  // R6 tvec untouched
    '{2'd0, 12'h300, 32'h0,        2'd1, 32'h40,  32'hF000FF0F, 1'b0, 1'b1, 32'h100, 8'd7},  // R7 ecall
    '{2'd0, 12'h341, 32'h0,        2'd0, 32'h0,   32'h40,       1'b0, 1'b0, 32'h0,   8'd7},
    '{2'd0, 12'h342, 32'h0,        2'd0, 32'h0,   32'hB,        1'b0, 1'b0, 32'h0,   8'd7},
    '{2'd1, 12'h305, 32'h999,      2'd2, 32'h84,  32'h100,      1'b0, 1'b1, 32'h100, 8'd8},  // R8 illegal + R11 write
    '{2'd0, 12'h305, 32'h0,        2'd0, 32'h0,   32'h100,      1'b0, 1'b0, 32'h0,   8'd11}, // R11 suppressed
    '{2'd0, 12'h342, 32'h0,        2'd0, 32'h0,   32'h2,        1'b0, 1'b0, 32'h0,   8'd8},
    '{2'd0, 12'h341, 32'h0,        2'd0, 32'h0,   32'h84,       1'b0, 1'b0, 32'h0,   8'd8},
    '{2'd2, 12'h300, 32'h1,        2'd3, 32'h200, 32'hF000FF0F, 1'b0, 1'b1, 32'h84,  8'd9},  // R9 return + R11
    '{2'd0, 12'h300, 32'h0,        2'd0, 32'h0,   32'hF000FF0F, 1'b0, 1'b0, 32'h0,   8'd11},
    '{2'd0, 12'h341, 32'h0,        2'd0, 32'h0,   32'h84,       1'b0, 1'b0, 32'h0,   8'd9},  // R9 no change
    '{2'd1, 12'h341, 32'h500,      2'd0, 32'h0,   32'h84,       1'b0, 1'b0, 32'h0,   8'd10}, // R10 no redirect
    '{2'd0, 12'h341, 32'h0,        2'd3, 32'h0,   32'h500,      1'b0, 1'b1, 32'h500, 8'd9}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] csr_addr = '0;
  logic [1:0]  csr_op = '0;
  logic [31:0] csr_operand = '0;
  logic [1:0]  trap_code = '0;
  logic [31:0] pc = '0;
  logic [31:0] csr_rdata, redirect_pc;
  logic        csr_illegal, redirect;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mtrap_csr uut (
    .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_op(csr_op),
    .csr_operand(csr_operand), .trap_code(trap_code), .pc(pc),
    .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
    .redirect(redirect), .redirect_pc(redirect_pc)
  );

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [11:0] a, input logic [31:0] d,
                       input logic [1:0] t, input logic [31:0] p);
    csr_op = op; csr_addr = a; csr_operand = d; trap_code = t; pc = p;
    #(CLK_PERIOD/4);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].op, VEC[i].addr, VEC[i].wd, VEC[i].trap, VEC[i].pc);
      chk(int'(VEC[i].req), $sformatf("vec %0d rdata", i), csr_rdata, VEC[i].rd);
      chk(int'(VEC[i].req), $sformatf("vec %0d illegal", i), 32'(csr_illegal), 32'(VEC[i].ill));
      chk(int'(VEC[i].req), $sformatf("vec %0d redirect", i), 32'(redirect), 32'(VEC[i].redir));
      if (VEC[i].redir)
        chk(int'(VEC[i].req), $sformatf("vec %0d target", i), redirect_pc, VEC[i].tgt);
      @(negedge clk);
    end
    // R5: operation 00 writes nothing even with an operand present
    drive(2'd0, 12'h342, 32'hFFFF_FFFF, 2'd0, 32'h0);
    @(negedge clk);
    drive(2'd0, 12'h342, 32'h0, 2'd0, 32'h0);
    chk(5, "op 00 no write", csr_rdata, 32'h2);
    // R2: every implemented address is legal
    chk(2, "0x342 legal", 32'(csr_illegal), 32'h0);
    // R1: mid-run reset clears everything
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    drive(2'd0, 12'h300, 32'h0, 2'd0, 32'h0); chk(1, "status after reset", csr_rdata, 32'h0);
    drive(2'd0, 12'h305, 32'h0, 2'd0, 32'h0); chk(1, "tvec after reset", csr_rdata, 32'h0);
    drive(2'd0, 12'h341, 32'h0, 2'd0, 32'h0); chk(1, "epc after reset", csr_rdata, 32'h0);
    drive(2'd0, 12'h342, 32'h0, 2'd0, 32'h0); chk(1, "cause after reset", csr_rdata, 32'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule